// File: doc/BRIEF.md
# CAN Mailbox Status Flag Bank

This block keeps the per-mailbox status flags of a sixteen-mailbox CAN controller. Mailbox 0 can only receive; mailboxes 1 to 15 can also transmit. Software sets transmit requests and cancel requests through a small register port. It clears completion and receive flags by writing ones. A protocol engine reports three kinds of one-cycle events, each tagged with a mailbox number: transmission finished, cancellation finished, and message received.

Six flag registers are kept: transmit pending, cancel request, transmit done, abort done, receive pending and receive overwrite. The pending-transmit and cancel-request vectors are also driven out directly, so the engine can see which mailboxes want service. Reads are registered and have no side effects. The bit-engine, message storage, acceptance filtering and interrupt logic sit outside this block.

Top module: `can_mbx_flags`

## Requirements
- R1: After reset every flag is 0, `tx_req` and `cxl_req` are 0, and `rd_data` reads 0 for every address.
- R2: In the four transmit registers (address 0 transmit pending, 1 cancel request, 2 transmit done, 3 abort done), mailboxes 15..9 sit on bits 15..9 and mailboxes 8..1 on bits 7..0. Bit 8 always reads 0, and writing to it has no effect. On `tx_req`/`cxl_req`, bit m is mailbox m and bit 0 is always 0.
- R3: Writing 1 to a bit of the transmit pending register (address 0) sets that mailbox's request. Writing 0 leaves it unchanged.
- R4: Writing 1 to the cancel request register (address 1) sets that mailbox's cancel request. The request returns to 0 by itself when a cancel-done or transmit-done event for that mailbox clears the pending bit.
- R5: A transmit-done event for mailbox m (1..15) sets its transmit-done flag and clears its pending and cancel-request bits.
- R6: A cancel-done event for mailbox m (1..15) sets its abort-done flag and clears its pending and cancel-request bits.
- R7: Transmit-done and abort-done flags are cleared only by writing 1 to their bit. Writing 0 leaves them unchanged.
- R8: A receive event for mailbox m (0..15) sets bit m of the receive pending register (address 4). Writing 1 to bit m clears it.
- R9: A receive event for a mailbox whose receive-pending bit is already 1 sets bit m of the overwrite register (address 5). Writing 1 clears it.
- R10: When a hardware set event and a software write-1-to-clear hit the same flag in the same cycle, the flag ends at 1.
- R11: `rd_data` shows, one cycle after `addr` is presented, the register contents as they stood before that clock edge. Reads change no flag. Addresses 6 and 7 read 0.
- R12: Transmit-done and cancel-done events that name mailbox 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register select for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| txd_vld | input | 1 | Transmit-done event |
| txd_id | input | 4 | Mailbox of transmit-done event |
| cxd_vld | input | 1 | Cancel-done event |
| cxd_id | input | 4 | Mailbox of cancel-done event |
| rxe_vld | input | 1 | Message-received event |
| rxe_id | input | 4 | Mailbox of received message |
| tx_req | output | 16 | Pending transmit requests, bit = mailbox |
| cxl_req | output | 16 | Pending cancel requests, bit = mailbox |

## Verification
The hardest case to reach is a hardware event and a software clear landing on the same flag in the same clock cycle. The stimulus gets there by driving the write strobe and the event pulse together from one task at the same falling edge. It does this both for a receive event against a receive-pending clear, which also has to raise the overwrite flag, and for a transmit-done event against a done-flag clear. A second hard case is the shifted transmit layout. It is covered by writing all ones and by the edge mailboxes 1, 8 and 9.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  localparam int NMBX  = 16;
  localparam int IDW   = $clog2(NMBX);
  localparam int BUSW  = 16;
  localparam logic [NMBX-1:0] TX_MASK = {{(NMBX-1){1'b1}}, 1'b0};

  typedef enum logic [2:0] {
    SEL_TXPEND = 3'd0,
    SEL_TXCXL  = 3'd1,
    SEL_TXDONE = 3'd2,
    SEL_ABDONE = 3'd3,
    SEL_RXPEND = 3'd4,
    SEL_OVWR   = 3'd5
  } reg_sel_e;

  // mailbox vector -> bus image of a transmit register (bit 8 unused)
  function automatic logic [BUSW-1:0] tx_to_bus(input logic [NMBX-1:0] v);
    return {v[15:9], 1'b0, v[8:1]};
  endfunction

  // bus image of a transmit register -> mailbox vector (mailbox 0 empty)
  function automatic logic [NMBX-1:0] bus_to_tx(input logic [BUSW-1:0] b);
    return {b[15:9], b[7:0], 1'b0};
  endfunction
endpackage

// File: rtl/mbx_evt_decode.sv
module mbx_evt_decode #(
  parameter int N   = 16,
  parameter int IDW = $clog2(N)
) (
  input  logic           vld,
  input  logic [IDW-1:0] id,
  output logic [N-1:0]   oh
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign oh[i] = vld && (id == IDW'(i));
  end
endmodule

// File: rtl/mbx_flag_vec.sv
module mbx_flag_vec #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  // set has priority over clear so no event is lost
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_v) | set_v;
  end
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
  import can_mbx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      sel,
  input  logic [NMBX-1:0] txpend,
  input  logic [NMBX-1:0] txcxl,
  input  logic [NMBX-1:0] txdone,
  input  logic [NMBX-1:0] abdone,
  input  logic [NMBX-1:0] rxpend,
  input  logic [NMBX-1:0] ovwr,
  output logic [BUSW-1:0] rd_data
);
  logic [BUSW-1:0] mux_d;

  always_comb begin
    unique case (sel)
      SEL_TXPEND: mux_d = tx_to_bus(txpend);
      SEL_TXCXL:  mux_d = tx_to_bus(txcxl);
      SEL_TXDONE: mux_d = tx_to_bus(txdone);
      SEL_ABDONE: mux_d = tx_to_bus(abdone);
      SEL_RXPEND: mux_d = BUSW'(rxpend);
      SEL_OVWR:   mux_d = BUSW'(ovwr);
      default:    mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux_d;
  end

  // R2: bit 8 of a transmit register image is always 0
  a_r2_gap_bit_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) <= 3'd3) |-> (rd_data[8] == 1'b0));
endmodule

// File: rtl/can_mbx_flags.sv
module can_mbx_flags
  import can_mbx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      addr,
  input  logic            wr_en,
  input  logic [BUSW-1:0] wr_data,
  output logic [BUSW-1:0] rd_data,
  input  logic            txd_vld,
  input  logic [IDW-1:0]  txd_id,
  input  logic            cxd_vld,
  input  logic [IDW-1:0]  cxd_id,
  input  logic            rxe_vld,
  input  logic [IDW-1:0]  rxe_id,
  output logic [NMBX-1:0] tx_req,
  output logic [NMBX-1:0] cxl_req
);
  logic [NMBX-1:0] txd_oh, cxd_oh, rxe_oh;
  logic [NMBX-1:0] txpend_q, txcxl_q, txdone_q, abdone_q, rxpend_q, ovwr_q;
  logic [NMBX-1:0] wr_tx_v, wr_rx_v, tx_fin;
  logic            hit_txpend, hit_txcxl, hit_txdone, hit_abdone, hit_rxpend, hit_ovwr;

  mbx_evt_decode #(.N(NMBX), .IDW(IDW)) u_dec_txd (.vld(txd_vld), .id(txd_id), .oh(txd_oh));
  mbx_evt_decode #(.N(NMBX), .IDW(IDW)) u_dec_cxd (.vld(cxd_vld), .id(cxd_id), .oh(cxd_oh));
  mbx_evt_decode #(.N(NMBX), .IDW(IDW)) u_dec_rxe (.vld(rxe_vld), .id(rxe_id), .oh(rxe_oh));

  assign wr_tx_v    = bus_to_tx(wr_data) & TX_MASK;
  assign wr_rx_v    = wr_data[NMBX-1:0];
  assign hit_txpend = wr_en && (addr == SEL_TXPEND);
  assign hit_txcxl  = wr_en && (addr == SEL_TXCXL);
  assign hit_txdone = wr_en && (addr == SEL_TXDONE);
  assign hit_abdone = wr_en && (addr == SEL_ABDONE);
  assign hit_rxpend = wr_en && (addr == SEL_RXPEND);
  assign hit_ovwr   = wr_en && (addr == SEL_OVWR);
  // mailbox 0 cannot transmit: its completion events are dropped
  assign tx_fin     = (txd_oh | cxd_oh) & TX_MASK;

  mbx_flag_vec #(.W(NMBX)) u_txpend (.clk(clk), .rst(rst),
    .set_v(hit_txpend ? wr_tx_v : '0), .clr_v(tx_fin), .q(txpend_q));
  mbx_flag_vec #(.W(NMBX)) u_txcxl (.clk(clk), .rst(rst),
    .set_v(hit_txcxl ? wr_tx_v : '0), .clr_v(tx_fin), .q(txcxl_q));
  mbx_flag_vec #(.W(NMBX)) u_txdone (.clk(clk), .rst(rst),
    .set_v(txd_oh & TX_MASK), .clr_v(hit_txdone ? wr_tx_v : '0), .q(txdone_q));
  mbx_flag_vec #(.W(NMBX)) u_abdone (.clk(clk), .rst(rst),
    .set_v(cxd_oh & TX_MASK), .clr_v(hit_abdone ? wr_tx_v : '0), .q(abdone_q));
  mbx_flag_vec #(.W(NMBX)) u_rxpend (.clk(clk), .rst(rst),
    .set_v(rxe_oh), .clr_v(hit_rxpend ? wr_rx_v : '0), .q(rxpend_q));
  mbx_flag_vec #(.W(NMBX)) u_ovwr (.clk(clk), .rst(rst),
    .set_v(rxe_oh & rxpend_q), .clr_v(hit_ovwr ? wr_rx_v : '0), .q(ovwr_q));

  mbx_rd_mux u_rd (.clk(clk), .rst(rst), .sel(addr),
    .txpend(txpend_q), .txcxl(txcxl_q), .txdone(txdone_q), .abdone(abdone_q),
    .rxpend(rxpend_q), .ovwr(ovwr_q), .rd_data(rd_data));

  assign tx_req  = txpend_q;
  assign cxl_req = txcxl_q;

  // R5: a done flag only rises for a mailbox named by a transmit-done event
  a_r5_done_needs_event: assert property (@(posedge clk) disable iff (rst)
    ((txdone_q & ~$past(txdone_q) & ~$past(txd_vld ? txd_oh : '0)) == '0));
  // R6: an abort flag only rises for a mailbox named by a cancel-done event
  a_r6_abort_needs_event: assert property (@(posedge clk) disable iff (rst)
    ((abdone_q & ~$past(abdone_q) & ~$past(cxd_oh)) == '0));
  // R9: overwrite only rises when a receive hit an already pending mailbox
  a_r9_ovwr_cause: assert property (@(posedge clk) disable iff (rst)
    ((ovwr_q & ~$past(ovwr_q) & ~($past(rxe_oh) & $past(rxpend_q))) == '0));
  // R4: a cancel request only rises after a write to the cancel register
  a_r4_cxl_from_write: assert property (@(posedge clk) disable iff (rst)
    ((txcxl_q & ~$past(txcxl_q)) != '0) |-> ($past(wr_en) && $past(addr) == SEL_TXCXL));
  // R12: mailbox 0 never holds transmit-side state
  a_r12_mbx0_rx_only: assert property (@(posedge clk) disable iff (rst)
    !(tx_req[0] || cxl_req[0] || txdone_q[0] || abdone_q[0]));
endmodule

// File: tb/sim_can_mbx_flags.sv
module sim_can_mbx_flags;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  addr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        txd_vld, cxd_vld, rxe_vld;
  logic [3:0]  txd_id, cxd_id, rxe_id;
  logic [15:0] tx_req, cxl_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mbx_flags u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .txd_vld(txd_vld), .txd_id(txd_id), .cxd_vld(cxd_vld),
    .cxd_id(cxd_id), .rxe_vld(rxe_vld), .rxe_id(rxe_id),
    .tx_req(tx_req), .cxl_req(cxl_req));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    addr = '0; wr_en = 0; wr_data = '0;
    txd_vld = 0; txd_id = '0; cxd_vld = 0; cxd_id = '0; rxe_vld = 0; rxe_id = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_inputs(); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  // kind: 0 transmit done, 1 cancel done, 2 receive
  task automatic evt(input int kind, input logic [3:0] id);
    @(negedge clk);
    case (kind)
      0: begin txd_vld = 1; txd_id = id; end
      1: begin cxd_vld = 1; cxd_id = id; end
      default: begin rxe_vld = 1; rxe_id = id; end
    endcase
    @(negedge clk); txd_vld = 0; cxd_vld = 0; rxe_vld = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); addr = a;
    @(negedge clk); chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx_req", tx_req, 16'h0);
    chk("R1 cxl_req", cxl_req, 16'h0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 16'h0, "R1 reset read");
  endtask

  task automatic t_layout();
    do_reset();
    wr(3'd0, 16'h0100);
    rd_chk(3'd0, 16'h0000, "R2 bit8 write ignored");
    wr(3'd0, 16'hFFFF);
    rd_chk(3'd0, 16'hFEFF, "R2 layout all ones");
    chk("R2 tx_req mapping", tx_req, 16'hFFFE);
    wr(3'd0, 16'h0000);
    rd_chk(3'd0, 16'hFEFF, "R3 write zero no effect");
  endtask

  task automatic t_tx_flow();
    do_reset();
    wr(3'd0, 16'h0281);              // mailboxes 9, 8, 1
    chk("R3 tx_req set", tx_req, 16'h0302);
    wr(3'd1, 16'h0201);              // cancel 9 and 1
    chk("R4 cxl_req set", cxl_req, 16'h0202);
    evt(0, 4'd9);
    rd_chk(3'd0, 16'h0081, "R5 pending cleared");
    rd_chk(3'd1, 16'h0001, "R4 cancel cleared by done");
    rd_chk(3'd2, 16'h0200, "R5 done set");
    evt(1, 4'd1);
    rd_chk(3'd0, 16'h0080, "R6 pending cleared");
    chk("R6 cancel cleared", cxl_req, 16'h0000);
    rd_chk(3'd3, 16'h0001, "R6 abort set");
    wr(3'd2, 16'h0000);
    rd_chk(3'd2, 16'h0200, "R7 write zero keeps done");
    wr(3'd2, 16'h0200);
    rd_chk(3'd2, 16'h0000, "R7 done cleared");
    wr(3'd3, 16'h0001);
    rd_chk(3'd3, 16'h0000, "R7 abort cleared");
  endtask

  task automatic t_rx();
    do_reset();
    evt(2, 4'd0);
    evt(2, 4'd8);
    rd_chk(3'd4, 16'h0101, "R8 rx pending set");
    rd_chk(3'd5, 16'h0000, "R9 no overwrite yet");
    evt(2, 4'd8);
    rd_chk(3'd5, 16'h0100, "R9 overwrite set");
    wr(3'd4, 16'h0001);
    rd_chk(3'd4, 16'h0100, "R8 rx pending cleared");
    wr(3'd5, 16'h0100);
    rd_chk(3'd5, 16'h0000, "R9 overwrite cleared");
  endtask

  task automatic t_collide();
    do_reset();
    evt(2, 4'd3);
    @(negedge clk); addr = 3'd4; wr_en = 1; wr_data = 16'h0008; rxe_vld = 1; rxe_id = 4'd3;
    @(negedge clk); wr_en = 0; wr_data = '0; rxe_vld = 0;
    rd_chk(3'd4, 16'h0008, "R10 rx set beats clear");
    rd_chk(3'd5, 16'h0008, "R10 overwrite on collision");
    evt(0, 4'd5);
    @(negedge clk); addr = 3'd2; wr_en = 1; wr_data = 16'h0010; txd_vld = 1; txd_id = 4'd5;
    @(negedge clk); wr_en = 0; wr_data = '0; txd_vld = 0;
    rd_chk(3'd2, 16'h0010, "R10 done set beats clear");
  endtask

  task automatic t_mbx0_and_read();
    do_reset();
    evt(0, 4'd0);
    evt(1, 4'd0);
    rd_chk(3'd2, 16'h0000, "R12 mbx0 done ignored");
    rd_chk(3'd3, 16'h0000, "R12 mbx0 abort ignored");
    evt(0, 4'd15);
    @(negedge clk); addr = 3'd2;
    @(negedge clk); chk("R11 read latency", rd_data, 16'h8000);
    @(negedge clk); chk("R11 repeat read no side effect", rd_data, 16'h8000);
    rd_chk(3'd6, 16'h0000, "R11 unused address");
    rd_chk(3'd2, 16'h8000, "R11 flag unchanged by reads");
  endtask

  initial begin
    idle_inputs(); rst = 1;
    t_reset();
    t_layout();
    t_tx_flow();
    t_rx();
    t_collide();
    t_mbx0_and_read();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule